// File: doc/BRIEF.md
# Condition Code Evaluator

This combinational block decides whether an instruction should execute. It looks at a 4-bit condition code and at four status flags: negative (N), zero (Z), carry (C) and overflow (V). The flags come from fixed bit positions of a 32-bit status word. The block implements all sixteen condition codes. These include single-flag tests, unsigned compound comparisons (higher, lower-or-same) and signed compound comparisons (greater-or-equal, less-than, greater-than, less-or-equal).

A mode select picks one of two instruction formats.

- **Wide path:** the condition code is the top nibble of a 32-bit instruction word.
- **Compact path:** a 16-bit instruction sits in the low half of the instruction input. Only a compact conditional branch carries a condition code, in its second nibble. Every other compact instruction executes unconditionally.

A second output marks the "always, unconditional" code, so that a later decode stage can give it special handling.

Top module: `cond_gate`

## Requirements
- R1: The flags are taken from the status word at these positions: N bit 31, Z bit 30, C bit 29, V bit 28. No other status bit affects any output.
- R2: Codes 0 to 7 pass on exactly one flag: 0 when Z=1, 1 when Z=0, 2 when C=1, 3 when C=0, 4 when N=1, 5 when N=0, 6 when V=1, 7 when V=0.
- R3: Code 8 passes when C=1 and Z=0. Code 9 passes when C=0 or Z=1.
- R4: Code 10 passes when N equals V. Code 11 passes when N differs from V.
- R5: Code 12 passes when Z=0 and N equals V. Code 13 passes when Z=1 or N differs from V.
- R6: Code 14 always passes and leaves `uncond_o` low.
- R7: Code 15 always passes and drives `uncond_o` high. `uncond_o` is high for no other case.
- R8: With `compact_i`=0, the code is `instr_i[31:28]`, and `instr_i[27:0]` has no effect.
- R9: With `compact_i`=1 and `instr_i[15:12]`=4'hD, the code is `instr_i[11:8]`, and `instr_i[31:16]` has no effect.
- R10: With `compact_i`=1 and `instr_i[15:12]` not 4'hD, `pass_o`=1 and `uncond_o`=0 for any flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| compact_i | input | 1 | 0 selects the 32-bit format, 1 selects the 16-bit format in the low half |
| instr_i | input | 32 | Instruction word |
| status_i | input | 32 | Status word holding the N, Z, C and V flags |
| pass_o | output | 1 | The instruction executes |
| uncond_o | output | 1 | The effective code is the unconditional code 15 |

## Verification
The bench builds the block with its default widths: a 32-bit instruction, a 16-bit compact half and a 32-bit status word. With these widths every code can be swept against every flag combination in both formats, so the complete 16-by-16 truth table is in reach on each path. The bench also sets the low status bits and the unused instruction bits to patterns that disagree with the expected result. This exposes any slip in a field position or a flag position.

// File: rtl/cond_gate_pkg.sv
package cond_gate_pkg;

  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    CC_ZS  = 4'd0,  CC_ZC  = 4'd1,  CC_CS  = 4'd2,  CC_CC  = 4'd3,
    CC_NS  = 4'd4,  CC_NC  = 4'd5,  CC_VS  = 4'd6,  CC_VC  = 4'd7,
    CC_UHI = 4'd8,  CC_ULS = 4'd9,  CC_SGE = 4'd10, CC_SLT = 4'd11,
    CC_SGT = 4'd12, CC_SLE = 4'd13, CC_ALW = 4'd14, CC_UNC = 4'd15
  } cc_code_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flag_set_t;

endpackage

// File: rtl/cond_gate_flags.sv
module cond_gate_flags
  import cond_gate_pkg::*;
#(
  parameter int STATUS_W = 32
) (
  input  logic [STATUS_W-1:0] status_i,
  output flag_set_t           flags_o
);
  localparam int NFLAGS = 4;
  localparam int TOP    = STATUS_W - 1;
  localparam int LOW    = STATUS_W - NFLAGS;

  logic [NFLAGS-1:0] picked;

  // flags occupy the top nibble, N highest
  for (genvar g = 0; g < NFLAGS; g++) begin : g_pick
    assign picked[g] = status_i[LOW + g];
  end

  assign flags_o = flag_set_t'(picked);

  logic unused_low;
  assign unused_low = ^status_i[LOW-1:0];

  always_comb begin
    a_r1_top_bit_is_n: assert (flags_o.n === status_i[TOP] || $isunknown(status_i[TOP]));
  end
endmodule

// File: rtl/cond_gate_field.sv
module cond_gate_field
  import cond_gate_pkg::*;
#(
  parameter int          INSTR_W      = 32,
  parameter int          HALF_W       = 16,
  parameter logic [3:0]  BRANCH_CLASS = 4'hD
) (
  input  logic               compact_i,
  input  logic [INSTR_W-1:0] instr_i,
  output cc_code_e           code_o,
  output logic               applies_o
);
  localparam int WIDE_LSB  = INSTR_W - CODE_W;
  localparam int CLASS_LSB = HALF_W - CODE_W;
  localparam int HALF_LSB  = CLASS_LSB - CODE_W;

  logic [CODE_W-1:0] wide_code;
  logic [CODE_W-1:0] half_code;
  logic [CODE_W-1:0] half_class;
  logic              is_branch;

  assign wide_code  = instr_i[INSTR_W-1:WIDE_LSB];
  assign half_class = instr_i[HALF_W-1:CLASS_LSB];
  assign half_code  = instr_i[CLASS_LSB-1:HALF_LSB];
  assign is_branch  = (half_class == BRANCH_CLASS);

  always_comb begin
    if (compact_i) begin
      code_o    = cc_code_e'(half_code);
      applies_o = is_branch;
    end else begin
      code_o    = cc_code_e'(wide_code);
      applies_o = 1'b1;
    end
  end

  logic unused_bits;
  assign unused_bits = ^{instr_i[WIDE_LSB-1:HALF_W], instr_i[HALF_LSB-1:0]};

  always_comb begin
    a_r8_wide_always_applies: assert (compact_i || applies_o);
  end
endmodule

// File: rtl/cond_gate_table.sv
module cond_gate_table
  import cond_gate_pkg::*;
(
  input  cc_code_e  code_i,
  input  flag_set_t flags_i,
  output logic      pass_o
);
  logic sign_ok;
  logic above;

  assign sign_ok = (flags_i.n == flags_i.v);
  assign above   = flags_i.c & ~flags_i.z;

  always_comb begin
    unique case (code_i)
      CC_ZS:  pass_o =  flags_i.z;
      CC_ZC:  pass_o = ~flags_i.z;
      CC_CS:  pass_o =  flags_i.c;
      CC_CC:  pass_o = ~flags_i.c;
      CC_NS:  pass_o =  flags_i.n;
      CC_NC:  pass_o = ~flags_i.n;
      CC_VS:  pass_o =  flags_i.v;
      CC_VC:  pass_o = ~flags_i.v;
      CC_UHI: pass_o =  above;
      CC_ULS: pass_o = ~above;
      CC_SGE: pass_o =  sign_ok;
      CC_SLT: pass_o = ~sign_ok;
      CC_SGT: pass_o =  sign_ok & ~flags_i.z;
      CC_SLE: pass_o = ~sign_ok |  flags_i.z;
      default: pass_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/cond_gate.sv
module cond_gate
  import cond_gate_pkg::*;
#(
  parameter int INSTR_W  = 32,
  parameter int HALF_W   = 16,
  parameter int STATUS_W = 32
) (
  input  logic                compact_i,
  input  logic [INSTR_W-1:0]  instr_i,
  input  logic [STATUS_W-1:0] status_i,
  output logic                pass_o,
  output logic                uncond_o
);
  cc_code_e  code;
  logic      applies;
  flag_set_t flags;
  logic      tbl_pass;

  cond_gate_field #(
    .INSTR_W      (INSTR_W),
    .HALF_W       (HALF_W),
    .BRANCH_CLASS (4'hD)
  ) u_field (
    .compact_i (compact_i),
    .instr_i   (instr_i),
    .code_o    (code),
    .applies_o (applies)
  );

  cond_gate_flags #(.STATUS_W(STATUS_W)) u_flags (
    .status_i (status_i),
    .flags_o  (flags)
  );

  cond_gate_table u_table (
    .code_i  (code),
    .flags_i (flags),
    .pass_o  (tbl_pass)
  );

  assign pass_o   = applies ? tbl_pass : 1'b1;
  assign uncond_o = applies & (code == CC_UNC);

  always_comb begin
    a_r7_uncond_implies_pass: assert (!uncond_o || pass_o);
    a_r6_code14_passes: assert (!(applies && code == CC_ALW) || (pass_o && !uncond_o));
    a_r10_plain_half_passes: assert (!(compact_i && !applies) || (pass_o && !uncond_o));
    a_r4_sign_pair: assert (!(applies && code == CC_SGE) || (pass_o == (flags.n == flags.v)));
  end
endmodule

// File: tb/cond_gate_bench.sv
module cond_gate_bench;
  logic        clk;
  logic        rst_n;
  logic        compact_i;
  logic [31:0] instr_i;
  logic [31:0] status_i;
  logic        pass_o;
  logic        uncond_o;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  cond_gate u_cond_gate (
    .compact_i (compact_i),
    .instr_i   (instr_i),
    .status_i  (status_i),
    .pass_o    (pass_o),
    .uncond_o  (uncond_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // expected result from the requirement text, flags as {n,z,c,v}
  function automatic bit ref_pass(input logic [3:0] code, input logic [3:0] f);
    bit n, z, c, v;
    n = f[3]; z = f[2]; c = f[1]; v = f[0];
    case (code)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return c;
      4'd3:  return !c;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return c && !z;
      4'd9:  return !c || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      default: return 1'b1;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] code);
    if (code < 8)        return "R2";
    else if (code < 10)  return "R3";
    else if (code < 12)  return "R4";
    else if (code < 14)  return "R5";
    else if (code == 14) return "R6";
    else                 return "R7";
  endfunction

  task automatic apply_and_check(input bit cmp, input logic [31:0] ins, input logic [31:0] st,
                                 input bit exp_p, input bit exp_u, input string req);
    @(negedge clk);
    compact_i = cmp; instr_i = ins; status_i = st;
    #2;
    checks++;
    if (pass_o !== exp_p || uncond_o !== exp_u) begin
      errors++;
      $display("FAIL %s: pass=%b uncond=%b expected pass=%b uncond=%b (ins=%h st=%h cmp=%b)",
               req, pass_o, uncond_o, exp_p, exp_u, ins, st, cmp);
    end
  endtask

  // R2..R7 and R8: full table on the wide path, junk in low instruction bits
  task automatic t_wide_table();
    for (int cd = 0; cd < 16; cd++)
      for (int f = 0; f < 16; f++)
        apply_and_check(1'b0, {cd[3:0], 28'h5A5_A5A5}, {f[3:0], 28'h0},
                        ref_pass(cd[3:0], f[3:0]), cd == 15, req_of(cd[3:0]));
  endtask

  // R1: low status bits must not matter; set them to complement patterns
  task automatic t_flag_positions();
    for (int cd = 0; cd < 14; cd++)
      for (int f = 0; f < 16; f++)
        apply_and_check(1'b0, {cd[3:0], 28'h0}, {f[3:0], 28'hFFF_FFFF},
                        ref_pass(cd[3:0], f[3:0]), 1'b0, "R1");
  endtask

  // R8: change low instruction bits, the result must not move
  task automatic t_wide_field();
    apply_and_check(1'b0, 32'h0FFF_FFFF, 32'h0000_0000, 1'b0, 1'b0, "R8");
    apply_and_check(1'b0, 32'h1000_0000, 32'h4FFF_FFFF, 1'b0, 1'b0, "R8");
    apply_and_check(1'b0, 32'h0000_DF00, 32'h0000_0000, 1'b0, 1'b0, "R8");
  endtask

  // R9: compact conditional branch, upper half carries a contradicting pattern
  task automatic t_compact_branch();
    for (int cd = 0; cd < 16; cd++)
      for (int f = 0; f < 16; f++)
        apply_and_check(1'b1, {4'(~cd[3:0]), 12'hFFF, 4'hD, cd[3:0], 8'hA5}, {f[3:0], 28'h0},
                        ref_pass(cd[3:0], f[3:0]), cd == 15, "R9");
  endtask

  // R10: other compact classes pass regardless of field and flags
  task automatic t_compact_plain();
    for (int cls = 0; cls < 16; cls++) begin
      if (cls == 13) continue;
      apply_and_check(1'b1, {16'hD000, cls[3:0], 4'h0, 8'h00}, 32'h0000_0000, 1'b1, 1'b0, "R10");
      apply_and_check(1'b1, {16'h0000, cls[3:0], 4'hF, 8'h00}, 32'hF000_0000, 1'b1, 1'b0, "R10");
    end
  endtask

  initial begin
    rst_n = 1'b0; compact_i = 1'b0; instr_i = '0; status_i = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset-state check: all-zero inputs mean code 0 with Z clear
    apply_and_check(1'b0, 32'h0, 32'h0, 1'b0, 1'b0, "R2");
    t_wide_table();
    t_flag_positions();
    t_wide_field();
    t_compact_branch();
    t_compact_plain();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule